// File: doc/BRIEF.md
# Debug Handshake Window

This block is a small memory-mapped window that sits on the bus of a CPU parked in debug mode. A debug controller on its other side uses it to trade handshakes with the CPU. The controller raises resume or execute requests and loads instructions into a program buffer. The CPU polls a status word, takes the request and answers with acknowledge writes. Those writes move a handshake state machine whose state the controller sees as four flags: halted, resuming, executing and exception.

The window is 512 bytes at a fixed base and is split into four 128-byte regions. The first holds constant park code, which the CPU only reads. The second is the program buffer, which the controller fills. The third is a data buffer that both sides can write. The fourth is the status word. The status word has split meaning. The bits the CPU reads are request flags driven by the controller. The bits the CPU writes are one-shot acknowledges, which move the state machine and retire pending requests. All CPU accesses finish in one cycle.

The handshake state machine has four states: `HS_RUNNING` (the reset state), `HS_PARKED`, `HS_RESUMING` and `HS_EXECUTING`. A status write takes one of three transitions, and these can fire from any state. The halt transition goes to `HS_PARKED` on acknowledge bit 0. The resume transition goes to `HS_RESUMING` on acknowledge bit 2. The execute transition goes to `HS_EXECUTING` on acknowledge bit 4. If one write carries more than one of these bits, execute wins over resume, and resume wins over halt.

Top module: `dbg_window`

## Requirements
- R1: An address whose bits [31:9] equal those of the base 0xFFFFF800 is inside the window, and bits [8:7] select the region: 0 is code, 1 is the program buffer, 2 is the data buffer and 3 is the status word. A read outside the window returns zero, and a write outside the window changes nothing.
- R2: A cycle with cpu_req high is followed by exactly one cycle with cpu_ready high. In that cycle cpu_rdata holds the read value, taken before any write at the same edge. cpu_rdata is zero whenever cpu_ready is low and after a write.
- R3: A code-region read returns 0xD0C5 in bits [31:16] and, in the low half, the word index addr[6:2] modulo CODE_WORDS (8 by default). CPU writes to the code region are ignored.
- R4: The program buffer and the data buffer each hold BUF_WORDS words (4 by default), indexed by addr[3:2] so that higher offsets alias. The controller writes a word with ctl_pbuf_we or ctl_dbuf_we at ctl_addr. CPU writes to the program buffer are ignored. The CPU may write the data buffer, but a controller write to the same word at the same edge wins.
- R5: A status write with bit 0 set, and with bits 2 and 4 clear, puts the block in `HS_PARKED` (st_halted=1 and the other state flags 0). At most one state flag is high at any time.
- R6: A status write with bit 4 set enters `HS_EXECUTING`. A write with bit 2 set and bit 4 clear enters `HS_RESUMING`. Each acknowledge bit clears its own pending request, whichever state is entered.
- R7: A ctl_resume_req or ctl_exec_req pulse sets its pending request only if st_halted is 1 at that edge; otherwise it is ignored. If an acknowledge clears the same request at the same edge, the clear wins.
- R8: A status read returns bit 3 as the pending execute request and bit 1 as the pending resume request. Bit 1 reads 1 only while no execute request is pending. All other bits read zero.
- R9: Execute and resume requests raised at the same edge are both kept. The CPU sees only the execute request, and the resume request becomes visible once the execute acknowledge retires the execute request.
- R10: A status write with bit 5 set raises st_exception without changing the state. The flag holds until ctl_exc_clr, and if a set and a clear arrive at the same edge the set wins.
- R11: After reset the state is `HS_RUNNING`, every flag and pending request is 0, cpu_ready is 0 and both buffers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access strobe, one access per cycle |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | CPU read data, valid with cpu_ready |
| cpu_ready | output | 1 | Access completion, one cycle after cpu_req |
| ctl_resume_req | input | 1 | Controller resume request pulse |
| ctl_exec_req | input | 1 | Controller execute request pulse |
| ctl_exc_clr | input | 1 | Controller clear of the exception flag |
| ctl_pbuf_we | input | 1 | Controller program-buffer write |
| ctl_dbuf_we | input | 1 | Controller data-buffer write |
| ctl_addr | input | $clog2(BUF_WORDS) | Controller buffer word index |
| ctl_wdata | input | DATA_W | Controller buffer write data |
| st_halted | output | 1 | State is HS_PARKED |
| st_resuming | output | 1 | State is HS_RESUMING |
| st_executing | output | 1 | State is HS_EXECUTING |
| st_exception | output | 1 | Sticky exception flag |

## Verification
Some properties are checked by assertions on every cycle. These are the one-cycle completion of each access, zero read data when ready is low, at most one state flag high, and the state each acknowledge write must reach. The exception flag's set, hold and clear rules are checked the same way.

Other rules depend on hidden pending-request state or on buffer contents, so only the bench's scenarios can show them. These include the read-side priority between execute and resume, and requests ignored while the CPU is not parked. They also include the clear-wins race between a request and its acknowledge, data-buffer write collisions, and code and buffer aliasing.

// File: rtl/dbgwin_pkg.sv
package dbgwin_pkg;

    // Region selected by address bits just above a region's offset.
    typedef enum logic [1:0] {
        RGN_CODE = 2'd0,
        RGN_PBUF = 2'd1,
        RGN_DBUF = 2'd2,
        RGN_STAT = 2'd3
    } region_e;

    // CPU-side handshake state.
    typedef enum logic [1:0] {
        HS_RUNNING   = 2'd0,
        HS_PARKED    = 2'd1,
        HS_RESUMING  = 2'd2,
        HS_EXECUTING = 2'd3
    } hs_state_e;

    // Status word bit positions (park code depends on these).
    localparam int SB_HALT_ACK   = 0;
    localparam int SB_RESUME_REQ = 1;
    localparam int SB_RESUME_ACK = 2;
    localparam int SB_EXEC_REQ   = 3;
    localparam int SB_EXEC_ACK   = 4;
    localparam int SB_EXC_ACK    = 5;

    // Each region spans 2**REGION_LG bytes.
    localparam int REGION_LG = 7;

    localparam logic [15:0] CODE_TAG = 16'hD0C5;

    // Constant park-code image, computed from the word index.
    function automatic logic [31:0] code_word(input logic [15:0] idx);
        return {CODE_TAG, idx};
    endfunction

endpackage

// File: rtl/dbgwin_decode.sv
module dbgwin_decode
    import dbgwin_pkg::*;
#(
    parameter int unsigned          ADDR_W    = 32,
    parameter logic [ADDR_W-1:0]    BASE_ADDR = 32'hFFFF_F800,
    localparam int unsigned         WIN_LG    = REGION_LG + 2,
    localparam int unsigned         WORD_W    = REGION_LG - 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win,
    output region_e           region,
    output logic [WORD_W-1:0] word
);

    logic byte_lane_unused;

    assign in_win           = (addr[ADDR_W-1:WIN_LG] == BASE_ADDR[ADDR_W-1:WIN_LG]);
    assign region           = region_e'(addr[WIN_LG-1:REGION_LG]);
    assign word             = addr[REGION_LG-1:2];
    assign byte_lane_unused = ^addr[1:0];

endmodule

// File: rtl/dbgwin_bufs.sv
module dbgwin_bufs #(
    parameter int unsigned  DATA_W    = 32,
    parameter int unsigned  BUF_WORDS = 4,
    localparam int unsigned IDX_W     = $clog2(BUF_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_pbuf_we,
    input  logic              ctl_dbuf_we,
    input  logic [IDX_W-1:0]  ctl_addr,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              cpu_dbuf_we,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] pbuf_rd,
    output logic [DATA_W-1:0] dbuf_rd
);

    logic [DATA_W-1:0] pbuf_q [BUF_WORDS];
    logic [DATA_W-1:0] dbuf_q [BUF_WORDS];

    for (genvar w = 0; w < BUF_WORDS; w++) begin : g_word
        logic ctl_hit;
        logic cpu_hit;

        assign ctl_hit = (ctl_addr == IDX_W'(w));
        assign cpu_hit = (cpu_idx  == IDX_W'(w));

        // Program buffer: controller is the only writer.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pbuf_q[w] <= '0;
            end else if (ctl_pbuf_we && ctl_hit) begin
                pbuf_q[w] <= ctl_wdata;
            end
        end

        // Data buffer: both sides write, controller wins a collision.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dbuf_q[w] <= '0;
            end else if (ctl_dbuf_we && ctl_hit) begin
                dbuf_q[w] <= ctl_wdata;
            end else if (cpu_dbuf_we && cpu_hit) begin
                dbuf_q[w] <= cpu_wdata;
            end
        end
    end

    assign pbuf_rd = pbuf_q[cpu_idx];
    assign dbuf_rd = dbuf_q[cpu_idx];

endmodule

// File: rtl/dbgwin_handshake.sv
module dbgwin_handshake
    import dbgwin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ack_wr,
    input  logic ack_halt,
    input  logic ack_resume,
    input  logic ack_exec,
    input  logic ack_exc,
    input  logic ctl_resume_req,
    input  logic ctl_exec_req,
    input  logic ctl_exc_clr,
    output logic halted,
    output logic resuming,
    output logic executing,
    output logic exception,
    output logic resume_pend,
    output logic exec_pend
);

    hs_state_e state_q;
    hs_state_e state_d;
    logic      resume_pend_q;
    logic      exec_pend_q;
    logic      exc_q;
    logic      resume_clr;
    logic      exec_clr;

    // Next state: execute over resume over halt within one write.
    always_comb begin
        state_d = state_q;
        if (ack_wr) begin
            if (ack_exec) begin
                state_d = HS_EXECUTING;
            end else if (ack_resume) begin
                state_d = HS_RESUMING;
            end else if (ack_halt) begin
                state_d = HS_PARKED;
            end
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_RUNNING;
        end else begin
            state_q <= state_d;
        end
    end

    // State outputs.
    always_comb begin
        halted    = 1'b0;
        resuming  = 1'b0;
        executing = 1'b0;
        unique case (state_q)
            HS_RUNNING:   begin end
            HS_PARKED:    halted    = 1'b1;
            HS_RESUMING:  resuming  = 1'b1;
            HS_EXECUTING: executing = 1'b1;
        endcase
    end

    assign resume_clr = ack_wr & ack_resume;
    assign exec_clr   = ack_wr & ack_exec;

    // Pending requests: accepted only while parked, acknowledge clear wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resume_pend_q <= 1'b0;
            exec_pend_q   <= 1'b0;
            exc_q         <= 1'b0;
        end else begin
            resume_pend_q <= resume_clr ? 1'b0 : (resume_pend_q | (ctl_resume_req & halted));
            exec_pend_q   <= exec_clr   ? 1'b0 : (exec_pend_q   | (ctl_exec_req   & halted));
            exc_q         <= (ack_wr & ack_exc) | (exc_q & ~ctl_exc_clr);
        end
    end

    assign resume_pend = resume_pend_q;
    assign exec_pend   = exec_pend_q;
    assign exception   = exc_q;

endmodule

// File: rtl/dbg_window.sv
module dbg_window
    import dbgwin_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 32,
    parameter int unsigned       DATA_W     = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 32'hFFFF_F800,
    parameter int unsigned       BUF_WORDS  = 4,
    parameter int unsigned       CODE_WORDS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cpu_req,
    input  logic                         cpu_we,
    input  logic [ADDR_W-1:0]            cpu_addr,
    input  logic [DATA_W-1:0]            cpu_wdata,
    output logic [DATA_W-1:0]            cpu_rdata,
    output logic                         cpu_ready,
    input  logic                         ctl_resume_req,
    input  logic                         ctl_exec_req,
    input  logic                         ctl_exc_clr,
    input  logic                         ctl_pbuf_we,
    input  logic                         ctl_dbuf_we,
    input  logic [$clog2(BUF_WORDS)-1:0] ctl_addr,
    input  logic [DATA_W-1:0]            ctl_wdata,
    output logic                         st_halted,
    output logic                         st_resuming,
    output logic                         st_executing,
    output logic                         st_exception
);

    localparam int unsigned IDX_W      = $clog2(BUF_WORDS);
    localparam int unsigned CODE_IDX_W = $clog2(CODE_WORDS);
    localparam int unsigned WORD_W     = REGION_LG - 2;

    logic              in_win;
    region_e           rgn;
    logic [WORD_W-1:0] word;
    logic              wr_hit;
    logic              stat_wr;
    logic              dbuf_wr;
    logic [DATA_W-1:0] pbuf_rd;
    logic [DATA_W-1:0] dbuf_rd;
    logic              resume_pend;
    logic              exec_pend;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] rdata_q;
    logic              ready_q;
    logic              word_unused;

    dbgwin_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .addr   (cpu_addr),
        .in_win (in_win),
        .region (rgn),
        .word   (word)
    );

    assign wr_hit      = cpu_req & cpu_we & in_win;
    assign stat_wr     = wr_hit & (rgn == RGN_STAT);
    assign dbuf_wr     = wr_hit & (rgn == RGN_DBUF);
    assign word_unused = ^word;

    dbgwin_bufs #(
        .DATA_W    (DATA_W),
        .BUF_WORDS (BUF_WORDS)
    ) u_bufs (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_pbuf_we (ctl_pbuf_we),
        .ctl_dbuf_we (ctl_dbuf_we),
        .ctl_addr    (ctl_addr),
        .ctl_wdata   (ctl_wdata),
        .cpu_dbuf_we (dbuf_wr),
        .cpu_idx     (word[IDX_W-1:0]),
        .cpu_wdata   (cpu_wdata),
        .pbuf_rd     (pbuf_rd),
        .dbuf_rd     (dbuf_rd)
    );

    dbgwin_handshake u_hs (
        .clk            (clk),
        .rst_n          (rst_n),
        .ack_wr         (stat_wr),
        .ack_halt       (cpu_wdata[SB_HALT_ACK]),
        .ack_resume     (cpu_wdata[SB_RESUME_ACK]),
        .ack_exec       (cpu_wdata[SB_EXEC_ACK]),
        .ack_exc        (cpu_wdata[SB_EXC_ACK]),
        .ctl_resume_req (ctl_resume_req),
        .ctl_exec_req   (ctl_exec_req),
        .ctl_exc_clr    (ctl_exc_clr),
        .halted         (st_halted),
        .resuming       (st_resuming),
        .executing      (st_executing),
        .exception      (st_exception),
        .resume_pend    (resume_pend),
        .exec_pend      (exec_pend)
    );

    // Read mux; the status word exposes only request bits.
    always_comb begin
        rd_val = '0;
        if (in_win) begin
            unique case (rgn)
                RGN_CODE: rd_val = DATA_W'(code_word(16'(word[CODE_IDX_W-1:0])));
                RGN_PBUF: rd_val = pbuf_rd;
                RGN_DBUF: rd_val = dbuf_rd;
                RGN_STAT: begin
                    rd_val[SB_EXEC_REQ]   = exec_pend;
                    rd_val[SB_RESUME_REQ] = resume_pend & ~exec_pend;
                end
            endcase
        end
    end

    // One-cycle response register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            ready_q <= cpu_req;
            rdata_q <= (cpu_req && !cpu_we) ? rd_val : '0;
        end
    end

    assign cpu_ready = ready_q;
    assign cpu_rdata = rdata_q;

endmodule

// File: rtl/dbg_window_chk.sv
module dbg_window_chk
    import dbgwin_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 32,
    parameter int unsigned       DATA_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_F800
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              cpu_ready,
    input logic              ctl_exc_clr,
    input logic              st_halted,
    input logic              st_resuming,
    input logic              st_executing,
    input logic              st_exception
);

    localparam int unsigned WIN_LG = REGION_LG + 2;

    logic stat_hit;
    logic exc_wr;
    logic chk_unused;

    assign stat_hit   = cpu_req && cpu_we
                        && (cpu_addr[ADDR_W-1:WIN_LG] == BASE_ADDR[ADDR_W-1:WIN_LG])
                        && (cpu_addr[WIN_LG-1:REGION_LG] == 2'b11);
    assign exc_wr     = stat_hit && cpu_wdata[SB_EXC_ACK];
    assign chk_unused = ^{cpu_addr[REGION_LG-1:0], cpu_wdata};

    p_ready_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |=> cpu_ready);

    p_ready_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req |=> !cpu_ready);

    p_rdata_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ready |-> (cpu_rdata == '0));

    p_state_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_halted, st_resuming, st_executing}));

    p_halt_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_hit && cpu_wdata[SB_HALT_ACK] && !cpu_wdata[SB_RESUME_ACK] && !cpu_wdata[SB_EXEC_ACK])
        |=> st_halted);

    p_exec_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_hit && cpu_wdata[SB_EXEC_ACK]) |=> st_executing);

    p_resume_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_hit && cpu_wdata[SB_RESUME_ACK] && !cpu_wdata[SB_EXEC_ACK]) |=> st_resuming);

    p_exc_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_wr |=> st_exception);

    p_exc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_exception && !ctl_exc_clr) |=> st_exception);

    p_exc_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_exc_clr && !exc_wr) |=> !st_exception);

    p_exc_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_exception && !exc_wr) |=> !st_exception);

endmodule

bind dbg_window dbg_window_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req      (cpu_req),
    .cpu_we       (cpu_we),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .cpu_rdata    (cpu_rdata),
    .cpu_ready    (cpu_ready),
    .ctl_exc_clr  (ctl_exc_clr),
    .st_halted    (st_halted),
    .st_resuming  (st_resuming),
    .st_executing (st_executing),
    .st_exception (st_exception)
);

// File: tb/dbg_window_bench.sv
module dbg_window_bench;

    localparam int          CLK_PERIOD = 10;
    localparam int          WD_CYCLES  = 20000;
    localparam logic [31:0] BASE       = 32'hFFFF_F800;
    localparam int          CODE_N     = 8;
    localparam int          BUF_N      = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        ctl_resume_req = 1'b0;
    logic        ctl_exec_req = 1'b0;
    logic        ctl_exc_clr = 1'b0;
    logic        ctl_pbuf_we = 1'b0;
    logic        ctl_dbuf_we = 1'b0;
    logic [1:0]  ctl_addr = '0;
    logic [31:0] ctl_wdata = '0;
    logic        st_halted, st_resuming, st_executing, st_exception;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_window u_dbg_window (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .ctl_resume_req(ctl_resume_req), .ctl_exec_req(ctl_exec_req), .ctl_exc_clr(ctl_exc_clr),
        .ctl_pbuf_we(ctl_pbuf_we), .ctl_dbuf_we(ctl_dbuf_we), .ctl_addr(ctl_addr),
        .ctl_wdata(ctl_wdata),
        .st_halted(st_halted), .st_resuming(st_resuming),
        .st_executing(st_executing), .st_exception(st_exception)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Behavioural reference model: 0 running, 1 parked, 2 resuming, 3 executing.
    int          m_state;
    bit          m_rp, m_ep, m_exc;
    logic [31:0] m_pb [BUF_N];
    logic [31:0] m_db [BUF_N];
    logic        m_ready;
    logic [31:0] m_rdata;
    bit          mv_win, mv_sw, mv_halted;
    int          mv_rg, mv_wi;
    logic [31:0] mv_rv;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_rp = 0; m_ep = 0; m_exc = 0;
            m_ready = 1'b0; m_rdata = '0;
            for (int i = 0; i < BUF_N; i++) begin m_pb[i] = '0; m_db[i] = '0; end
        end else begin
            mv_win = ((cpu_addr >> 9) == (BASE >> 9));
            mv_rg  = int'(cpu_addr[8:7]);
            mv_wi  = int'(cpu_addr[6:2]);
            mv_rv  = '0;
            if (mv_win) begin
                case (mv_rg)
                    0: mv_rv = {16'hD0C5, 16'(mv_wi % CODE_N)};
                    1: mv_rv = m_pb[mv_wi % BUF_N];
                    2: mv_rv = m_db[mv_wi % BUF_N];
                    default: begin
                        if (m_ep) mv_rv = 32'd8;
                        else if (m_rp) mv_rv = 32'd2;
                    end
                endcase
            end
            m_ready = cpu_req;
            m_rdata = (cpu_req && !cpu_we) ? mv_rv : 32'd0;
            mv_sw     = cpu_req && cpu_we && mv_win && (mv_rg == 3);
            mv_halted = (m_state == 1);
            if (ctl_resume_req && mv_halted) m_rp = 1;
            if (ctl_exec_req && mv_halted) m_ep = 1;
            if (mv_sw && cpu_wdata[2]) m_rp = 0;
            if (mv_sw && cpu_wdata[4]) m_ep = 0;
            if (mv_sw) begin
                if (cpu_wdata[4]) m_state = 3;
                else if (cpu_wdata[2]) m_state = 2;
                else if (cpu_wdata[0]) m_state = 1;
            end
            if (ctl_exc_clr) m_exc = 0;
            if (mv_sw && cpu_wdata[5]) m_exc = 1;
            if (ctl_pbuf_we) m_pb[ctl_addr] = ctl_wdata;
            if (cpu_req && cpu_we && mv_win && (mv_rg == 2)
                && !(ctl_dbuf_we && int'(ctl_addr) == mv_wi % BUF_N))
                m_db[mv_wi % BUF_N] = cpu_wdata;
            if (ctl_dbuf_we) m_db[ctl_addr] = ctl_wdata;
        end
    end

    // Compare against the model every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 cpu_ready vs model", 32'(cpu_ready), 32'(m_ready));
            check("R1 cpu_rdata vs model", cpu_rdata, m_rdata);
            check("R5 st_halted vs model", 32'(st_halted), 32'(m_state == 1));
            check("R6 st_resuming vs model", 32'(st_resuming), 32'(m_state == 2));
            check("R6 st_executing vs model", 32'(st_executing), 32'(m_state == 3));
            check("R10 st_exception vs model", 32'(st_exception), 32'(m_exc));
        end
    end

    task automatic cpu_wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        check("R2 write completes", {cpu_ready, cpu_rdata[30:0]}, 32'h8000_0000);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic cpu_rd(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        @(negedge clk);
        check("R2 read ready", 32'(cpu_ready), 32'd1);
        d = cpu_rdata;
        cpu_req = 1'b0;
    endtask

    task automatic ctl_pulse(input bit rr, input bit er, input bit clr);
        @(negedge clk);
        ctl_resume_req = rr; ctl_exec_req = er; ctl_exc_clr = clr;
        @(negedge clk);
        ctl_resume_req = 1'b0; ctl_exec_req = 1'b0; ctl_exc_clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    localparam logic [31:0] A_CODE = BASE;
    localparam logic [31:0] A_PBUF = BASE + 32'h080;
    localparam logic [31:0] A_DBUF = BASE + 32'h100;
    localparam logic [31:0] A_STAT = BASE + 32'h180;

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        check("R11 reset flags", {28'd0, st_halted, st_resuming, st_executing, st_exception}, 32'd0);
        check("R11 reset ready", 32'(cpu_ready), 32'd0);
        cpu_rd(A_DBUF + 32'hC, rd); check("R11 dbuf cleared", rd, 32'd0);
        cpu_rd(A_STAT, rd);         check("R8 status idle", rd, 32'd0);

        // R3: code region contents, aliasing, write ignored
        cpu_rd(A_CODE, rd);          check("R3 code word 0", rd, 32'hD0C5_0000);
        cpu_rd(A_CODE + 32'h4, rd);  check("R3 exception entry word", rd, 32'hD0C5_0001);
        cpu_rd(A_CODE + 32'h24, rd); check("R3 code alias word 9", rd, 32'hD0C5_0001);
        cpu_wr(A_CODE + 32'h8, 32'hDEAD_BEEF);
        cpu_rd(A_CODE + 32'h8, rd);  check("R3 code write ignored", rd, 32'hD0C5_0002);

        // R1: outside the window
        cpu_wr(32'h7FFF_F900, 32'h1234_5678);
        cpu_rd(32'h7FFF_F900, rd);   check("R1 outside read zero", rd, 32'd0);
        cpu_rd(A_DBUF, rd);          check("R1 outside write no effect", rd, 32'd0);

        // R7: request while running ignored
        ctl_pulse(1'b1, 1'b1, 1'b0);
        cpu_rd(A_STAT, rd);          check("R7 request while running ignored", rd, 32'd0);

        // R5: halt acknowledge
        cpu_wr(A_STAT, 32'h1);
        check("R5 parked flags", {29'd0, st_halted, st_resuming, st_executing}, 32'h4);

        // R4: program buffer
        for (int i = 0; i < BUF_N; i++) begin
            @(negedge clk);
            ctl_pbuf_we = 1'b1; ctl_addr = 2'(i); ctl_wdata = 32'h1000 + 32'(i);
        end
        @(negedge clk); ctl_pbuf_we = 1'b0;
        cpu_rd(A_PBUF + 32'h4, rd);  check("R4 pbuf word 1", rd, 32'h1001);
        cpu_rd(A_PBUF + 32'hC, rd);  check("R4 pbuf word 3", rd, 32'h1003);
        cpu_rd(A_PBUF + 32'h10, rd); check("R4 pbuf alias word 4", rd, 32'h1000);
        cpu_wr(A_PBUF + 32'h4, 32'h0BAD);
        cpu_rd(A_PBUF + 32'h4, rd);  check("R4 pbuf cpu write ignored", rd, 32'h1001);

        // R4: data buffer, including a same-word collision
        cpu_wr(A_DBUF + 32'h4, 32'hAAAA);
        cpu_rd(A_DBUF + 32'h4, rd);  check("R4 dbuf cpu write", rd, 32'hAAAA);
        @(negedge clk);
        ctl_dbuf_we = 1'b1; ctl_addr = 2'd2; ctl_wdata = 32'h5555;
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = A_DBUF + 32'h8; cpu_wdata = 32'h7777;
        @(negedge clk);
        ctl_dbuf_we = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0;
        cpu_rd(A_DBUF + 32'h8, rd);  check("R4 dbuf controller wins", rd, 32'h5555);

        // R8/R9: simultaneous requests, execute first
        ctl_pulse(1'b1, 1'b1, 1'b0);
        cpu_rd(A_STAT, rd);          check("R8 execute masks resume", rd, 32'h8);
        cpu_wr(A_STAT, 32'h10);
        check("R6 execute ack state", {31'd0, st_executing}, 32'd1);
        cpu_rd(A_STAT, rd);          check("R9 resume still pending", rd, 32'h2);

        // R7: request while executing ignored
        ctl_pulse(1'b0, 1'b1, 1'b0);
        cpu_rd(A_STAT, rd);          check("R7 request while executing ignored", rd, 32'h2);

        // R6: resume acknowledge clears the resume request
        cpu_wr(A_STAT, 32'h1);
        cpu_wr(A_STAT, 32'h4);
        check("R6 resume ack state", {30'd0, st_halted, st_resuming}, 32'h1);
        cpu_rd(A_STAT, rd);          check("R6 resume retired", rd, 32'd0);

        // R7: request and its acknowledge at one edge, clear wins
        cpu_wr(A_STAT, 32'h1);
        @(negedge clk);
        ctl_resume_req = 1'b1;
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = A_STAT; cpu_wdata = 32'h4;
        @(negedge clk);
        ctl_resume_req = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0;
        cpu_rd(A_STAT, rd);          check("R7 clear wins race", rd, 32'd0);

        // R6: acknowledge priority within one write
        cpu_wr(A_STAT, 32'h1);
        cpu_wr(A_STAT, 32'h15);
        check("R6 ack priority", {29'd0, st_halted, st_resuming, st_executing}, 32'h1);

        // R10: sticky exception
        cpu_wr(A_STAT, 32'h20);
        check("R10 exception set", {30'd0, st_exception, st_executing}, 32'h3);
        repeat (3) @(negedge clk);
        check("R10 exception sticky", 32'(st_exception), 32'd1);
        @(negedge clk);
        ctl_exc_clr = 1'b1;
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = A_STAT; cpu_wdata = 32'h20;
        @(negedge clk);
        ctl_exc_clr = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0;
        check("R10 set wins over clear", 32'(st_exception), 32'd1);
        ctl_pulse(1'b0, 1'b0, 1'b1);
        check("R10 exception cleared", 32'(st_exception), 32'd0);

        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule